// File: doc/BRIEF.md
# Interleaved NAND Die Read Scheduler

This block runs page reads on several NAND dies that sit on one shared data bus. A die that has been sent a read command needs a long internal busy period to load the page into its buffer. The scheduler fills that time by letting other dies stream their already loaded pages over the bus. The busy time and the page transfer length are parameters counted in clock cycles, and each die has its own counter.

Read requests carry a die index and a page address and arrive over a valid/ready handshake. Each die has a one-entry waiting slot. A request aimed at a die that is still working waits in that slot, and requests for the other dies keep flowing. When a die is idle and has a waiting request, the block pulses that die's command strobe and starts timing its busy period. Dies whose pages are loaded compete for the shared bus in round-robin order. A grant lasts for exactly one page transfer. A completion pulse then reports the die and the page, in the order in which the transfers finish.

Top module: `nand_rd_sched`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_strobe`, `bus_grant` and `done_valid` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 exactly when the waiting slot of the die selected by `req_die` is empty, so it depends only on that die.
- R3: When a die is idle and its slot holds a request, the die's `cmd_strobe` bit is 1 for exactly one cycle, in the cycle after the edge where the slot was filled. The slot is freed on that same edge, so a second request for the die is accepted one edge later.
- R4: A die's busy period lasts `BUSY_CYC` cycles, counted from its strobe cycle. If the bus is free, the die's grant starts `BUSY_CYC + 1` cycles after its strobe cycle.
- R5: At most one bit of `bus_grant` is 1 in any cycle. Each grant stays on for exactly `XFER_CYC` cycles.
- R6: When another die is already loaded, its grant starts in the cycle right after the previous owner's last transfer cycle.
- R7: Loaded dies are granted round-robin. The search starts at the die after the most recent owner, with indexes increasing and wrapping from `NUM_DIES-1` to 0.
- R8: `done_valid` is 1 for one cycle, in the cycle after a grant's last cycle. It carries that transfer's die in `done_die` and its page in `done_page`, so completions follow the finishing order and not the request order.
- R9: A request waiting for a die is issued as a command in the cycle after that die's completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Slot of the addressed die is free |
| req_die | input | DIE_W | Target die of the request |
| req_page | input | PAGE_W | Page address of the request |
| cmd_strobe | output | NUM_DIES | One-cycle page-read command pulse per die |
| bus_grant | output | NUM_DIES | One-hot owner of the shared data bus |
| done_valid | output | 1 | Transfer finished |
| done_die | output | DIE_W | Die of the finished transfer |
| done_page | output | PAGE_W | Page of the finished transfer |

## Verification
Each result has a fixed offset from the edge that accepts a request. With accept edge `a`, the strobe is seen in cycle `a+1`. On an idle bus, the grant starts in cycle `a+BUSY_CYC+2`, and the completion comes `XFER_CYC` cycles after the grant starts. Queued dies follow back to back, `XFER_CYC` apart. The bench drives inputs and samples outputs on the falling edge. A monitor stamps every strobe, grant edge and completion with a rising-edge cycle counter, and each scenario compares those stamps with offsets it works out from the accept edges that the send task returns.

// File: rtl/nand_rd_sched_pkg.sv
// Shared types for the NAND die read scheduler.
package nand_rd_sched_pkg;
    // Per-die life cycle of one page read
    typedef enum logic [1:0] {
        DIE_IDLE  = 2'd0,
        DIE_BUSY  = 2'd1,
        DIE_READY = 2'd2,
        DIE_XFER  = 2'd3
    } die_state_t;
endpackage

// File: rtl/nand_die_ctl.sv
// One die's read sequencer.
// Holds a one-entry waiting slot and the active page. It issues a command
// strobe, times the busy period, waits for a bus grant and then times the
// transfer. Assumes BUSY_CYC >= 1 and XFER_CYC >= 1, and that take_i is
// raised only while ready_o is 1.
module nand_die_ctl
    import nand_rd_sched_pkg::*;
#(
    parameter int PAGE_W   = 16,
    parameter int BUSY_CYC = 20,
    parameter int XFER_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic              ready_o,
    output logic              xfer_o,
    output logic              last_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              cmd_o
);
    localparam int MAXC  = (BUSY_CYC > XFER_CYC) ? BUSY_CYC : XFER_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    die_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              pend_v;
    logic [PAGE_W-1:0] pend_pg;

    // Sequence the slot, the command, the busy wait and the transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= DIE_IDLE;
            cnt     <= '0;
            pend_v  <= 1'b0;
            pend_pg <= '0;
            page_o  <= '0;
            cmd_o   <= 1'b0;
        end else begin
            cmd_o <= 1'b0;
            if (acc_i) begin
                pend_v  <= 1'b1;
                pend_pg <= page_i;
            end
            case (state)
                DIE_IDLE: if (pend_v) begin
                    state  <= DIE_BUSY;
                    cnt    <= CNT_W'(BUSY_CYC - 1);
                    page_o <= pend_pg;
                    pend_v <= 1'b0;
                    cmd_o  <= 1'b1;
                end
                DIE_BUSY: if (cnt == '0) state <= DIE_READY;
                          else cnt <= cnt - 1'b1;
                DIE_READY: if (take_i) begin
                    state <= DIE_XFER;
                    cnt   <= CNT_W'(XFER_CYC - 1);
                end
                default: if (cnt == '0) state <= DIE_IDLE;
                         else cnt <= cnt - 1'b1;
            endcase
        end
    end

    // Status seen by the arbiter and the top level
    always_comb begin
        pend_o  = pend_v;
        ready_o = (state == DIE_READY);
        xfer_o  = (state == DIE_XFER);
        last_o  = (state == DIE_XFER) && (cnt == '0);
    end
endmodule

// File: rtl/nand_bus_arb.sv
// Round-robin bus arbiter.
// When the bus is free it picks the first loaded die after the most recent
// owner. It assumes the caller reports the bus free only when no transfer is
// running or the running one is in its last cycle.
module nand_bus_arb #(
    parameter int NUM_DIES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DIES-1:0] ready_i,
    input  logic                free_i,
    output logic [NUM_DIES-1:0] take_o
);
    localparam int DIE_W = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1;

    logic [DIE_W-1:0] last_owner;
    logic [DIE_W-1:0] sel;
    logic             found;

    // Search from the die after the last owner, wrapping around
    always_comb begin
        take_o = '0;
        sel    = last_owner;
        found  = 1'b0;
        for (int k = 1; k <= NUM_DIES; k++) begin
            int idx;
            idx = (int'(last_owner) + k) % NUM_DIES;
            if (!found && free_i && ready_i[idx]) begin
                found       = 1'b1;
                sel         = DIE_W'(idx);
                take_o[idx] = 1'b1;
            end
        end
    end

    // Remember the most recent owner
    always_ff @(posedge clk) begin
        if (!rst_n)     last_owner <= DIE_W'(NUM_DIES - 1);
        else if (found) last_owner <= sel;
    end
endmodule

// File: rtl/nand_rd_sched.sv
// Interleaved NAND die read scheduler, top level.
// Routes requests into per-die slots, runs one sequencer per die, shares the
// data bus through a round-robin arbiter and reports finished transfers.
// Assumes req_die < NUM_DIES whenever req_valid is 1.
module nand_rd_sched
    import nand_rd_sched_pkg::*;
#(
    parameter int NUM_DIES = 4,
    parameter int PAGE_W   = 16,
    parameter int BUSY_CYC = 20,
    parameter int XFER_CYC = 8,
    localparam int DIE_W   = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [DIE_W-1:0]    req_die,
    input  logic [PAGE_W-1:0]   req_page,
    output logic [NUM_DIES-1:0] cmd_strobe,
    output logic [NUM_DIES-1:0] bus_grant,
    output logic                done_valid,
    output logic [DIE_W-1:0]    done_die,
    output logic [PAGE_W-1:0]   done_page
);
    logic [NUM_DIES-1:0] pend, rdy, xfer, last, take, acc;
    logic [PAGE_W-1:0]   act_pg [NUM_DIES];
    logic                bus_free;
    logic [DIE_W-1:0]    fin_die;
    logic [PAGE_W-1:0]   fin_page;

    // Accept when the addressed die's slot is empty
    always_comb begin
        req_ready = (int'(req_die) < NUM_DIES) ? !pend[req_die] : 1'b0;
        acc       = '0;
        if (req_valid && req_ready) acc[req_die] = 1'b1;
    end

    for (genvar d = 0; d < NUM_DIES; d++) begin : g_die
        nand_die_ctl #(
            .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC), .XFER_CYC(XFER_CYC)
        ) u_die (
            .clk(clk), .rst_n(rst_n),
            .acc_i(acc[d]), .page_i(req_page), .take_i(take[d]),
            .pend_o(pend[d]), .ready_o(rdy[d]), .xfer_o(xfer[d]),
            .last_o(last[d]), .page_o(act_pg[d]), .cmd_o(cmd_strobe[d])
        );
    end

    // Bus is free when idle or when the owner is in its last cycle
    always_comb bus_free = (xfer == '0) || (last != '0);

    nand_bus_arb #(.NUM_DIES(NUM_DIES)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .ready_i(rdy), .free_i(bus_free), .take_o(take)
    );

    always_comb bus_grant = xfer;

    // Pick out the die that is finishing this cycle
    always_comb begin
        fin_die  = '0;
        fin_page = '0;
        for (int d = 0; d < NUM_DIES; d++) begin
            if (last[d]) begin
                fin_die  = DIE_W'(d);
                fin_page = act_pg[d];
            end
        end
    end

    // Register the completion report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_die   <= '0;
            done_page  <= '0;
        end else begin
            done_valid <= (last != '0);
            done_die   <= fin_die;
            done_page  <= fin_page;
        end
    end
endmodule

// File: rtl/nand_rd_sched_chk.sv
// Property checker for nand_rd_sched, attached with bind.
// Works on the top-level ports only, plus one grant-length counter.
module nand_rd_sched_chk #(
    parameter int NUM_DIES = 4,
    parameter int XFER_CYC = 8,
    parameter int DIE_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_DIES-1:0] cmd_strobe,
    input logic [NUM_DIES-1:0] bus_grant,
    input logic                done_valid,
    input logic [DIE_W-1:0]    done_die
);
    logic [NUM_DIES-1:0] prev_g;
    logic [15:0]         run;

    // Count how long the previous grant value was held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_g <= '0;
            run    <= '0;
        end else begin
            prev_g <= bus_grant;
            run    <= (bus_grant != prev_g) ? 16'd1 : run + 16'd1;
        end
    end

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));

    assert_grant_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_g != '0 && bus_grant != prev_g) |-> (int'(run) == XFER_CYC));

    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != '0) |=> ((cmd_strobe & $past(cmd_strobe)) == '0));

    assert_no_cmd_during_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_strobe & bus_grant) == '0));

    assert_done_follows_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant[0]) |-> (done_valid && done_die == '0));
endmodule

bind nand_rd_sched nand_rd_sched_chk #(
    .NUM_DIES(NUM_DIES), .XFER_CYC(XFER_CYC), .DIE_W(DIE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .bus_grant(bus_grant),
    .done_valid(done_valid), .done_die(done_die)
);

// File: tb/nand_rd_sched_tb.sv
// Directed bench for nand_rd_sched: one task per scenario.
module nand_rd_sched_tb;
    localparam int N = 4, PW = 16, B = 20, X = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_die = '0;
    logic [PW-1:0] req_page = '0;
    logic [N-1:0]  cmd_strobe, bus_grant;
    logic          done_valid;
    logic [1:0]    done_die;
    logic [PW-1:0] done_page;

    nand_rd_sched #(.NUM_DIES(N), .PAGE_W(PW), .BUSY_CYC(B), .XFER_CYC(X)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_die(req_die), .req_page(req_page), .cmd_strobe(cmd_strobe),
        .bus_grant(bus_grant), .done_valid(done_valid), .done_die(done_die),
        .done_page(done_page)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    int cmd_cyc [N];
    int gstart [N];
    int glen [N];
    int dn_die [32], dn_page [32], dn_cyc [32];
    int dn_n = 0, overlap = 0;
    logic [N-1:0] prev_grant = '0;

    // Monitor: timestamp strobes, grant edges and completions
    always @(negedge clk) begin
        for (int d = 0; d < N; d++) begin
            if (cmd_strobe[d]) cmd_cyc[d] = cyc;
            if (bus_grant[d] && !prev_grant[d]) gstart[d] = cyc;
            if (!bus_grant[d] && prev_grant[d]) glen[d] = cyc - gstart[d];
        end
        if ($countones(bus_grant) > 1) overlap++;
        if (done_valid && dn_n < 32) begin
            dn_die[dn_n] = int'(done_die);
            dn_page[dn_n] = int'(done_page);
            dn_cyc[dn_n] = cyc;
            dn_n++;
        end
        prev_grant = bus_grant;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one request and return the edge that accepted it
    task automatic send(input int d, input int p, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_die = 2'(d); req_page = PW'(p);
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        acc = cyc + 1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (B + 5 * X + 10) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 cmd_strobe", int'(cmd_strobe), 0);
        chk("R1 bus_grant", int'(bus_grant), 0);
        chk("R1 done_valid", int'(done_valid), 0);
    endtask

    task automatic t_single();
        int a;
        dn_n = 0;
        send(1, 'h123, a);
        settle();
        chk("R3 strobe cycle", cmd_cyc[1], a + 1);
        chk("R4 grant start", gstart[1], a + B + 2);
        chk("R5 grant length", glen[1], X);
        chk("R8 done count", dn_n, 1);
        chk("R8 done cycle", dn_cyc[0], a + B + 2 + X);
        chk("R8 done die", dn_die[0], 1);
        chk("R8 done page", dn_page[0], 'h123);
    endtask

    task automatic t_all_dies();
        int a [N];
        dn_n = 0;
        for (int d = 0; d < N; d++) send(d, 'h200 + d, a[d]);
        settle();
        chk("R8 done count", dn_n, N);
        for (int d = 0; d < N; d++) begin
            chk("R6 back-to-back done cycle", dn_cyc[d], a[0] + B + 2 + X * (d + 1));
            chk("R8 done die order", dn_die[d], d);
            chk("R8 done page", dn_page[d], 'h200 + d);
        end
    endtask

    task automatic t_round_robin();
        int a [N];
        int ord [N];
        int exp_die [N];
        ord = '{1, 0, 3, 2};
        exp_die = '{1, 2, 3, 0};
        dn_n = 0;
        for (int i = 0; i < N; i++) send(ord[i], 'h300 + ord[i], a[i]);
        settle();
        chk("R8 done count", dn_n, N);
        for (int i = 0; i < N; i++) begin
            chk("R7 round-robin die", dn_die[i], exp_die[i]);
            chk("R7 round-robin cycle", dn_cyc[i], a[0] + B + 2 + X * (i + 1));
        end
    endtask

    task automatic t_busy_wait();
        int aa, ab, ac;
        dn_n = 0;
        send(2, 'h41, aa);
        send(2, 'h42, ab);
        send(3, 'h43, ac);
        chk("R3 slot frees on strobe edge", ab, aa + 2);
        chk("R2 other die not blocked", ac, ab + 1);
        @(negedge clk);
        req_valid = 1'b1; req_die = 2'd2; #1;
        chk("R2 ready low for full slot", int'(req_ready), 0);
        req_die = 2'd0; #1;
        chk("R2 ready high for other die", int'(req_ready), 1);
        req_valid = 1'b0;
        settle();
        chk("R8 done count", dn_n, 3);
        chk("R8 first done die", dn_die[0], 2);
        chk("R8 first done page", dn_page[0], 'h41);
        chk("R8 second done die", dn_die[1], 3);
        chk("R6 second done cycle", dn_cyc[1], dn_cyc[0] + X);
        chk("R9 queued strobe cycle", cmd_cyc[2], dn_cyc[0] + 1);
        chk("R8 third done page", dn_page[2], 'h42);
        chk("R4 third done cycle", dn_cyc[2], dn_cyc[0] + B + 2 + X);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_single();
        t_all_dies();
        t_round_robin();
        t_busy_wait();
        chk("R5 grant overlap cycles", overlap, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule